// File: doc/BRIEF.md
# Second-Level Cache Allocation Policy Filter

This block sits in the request path between the first-level miss traffic and a second-level cache. For every request it decides whether the second-level tags may be looked up and whether a miss may claim a new line. It reports whether the request must go around the cache and whether a store must also be written to the system bus. When a line is written or allocated, it also gives the coherence state that line receives. A small control register holds the enable, data-only, instruction-only and write-through settings. A walking sequencer clears the line status of every set after a global invalidate. The tag and data arrays are outside the block; they act on its verdicts and on the sequencer's set index.

Each request is judged with the control values that were held before the request's cycle. A control load therefore affects only later requests. The verdict is registered and appears one cycle after the request. The invalidate sequencer has two states. SEQ_IDLE moves to SEQ_WALK on an accepted invalidate (transition GO). SEQ_WALK steps the set index once per cycle and returns to SEQ_IDLE after the last set (transition DONE). An invalidate request made while the cache is enabled is refused and raises a sticky error flag.

Top module: `l2_alloc_filter`

## Requirements
- R1: After reset all control bits are clear, every response output is 0, `inv_busy` is 0 and `inv_err` is 0.
- R2: While the held enable bit is 0, a request gets bypass=1 with lookup=0, alloc=0 and set_state=0. bus_wr is 1 exactly for writes. Request kinds are 0 = instruction fetch, 1 = data read, 2 = data write; 3 acts as a data read.
- R3: A control load takes effect from the request after it. A request in the same cycle as the load is judged with the previous values.
- R4: Each request produces exactly one response with `rsp_valid` high in the following cycle.
- R5: When enabled, a hit gives lookup=1, alloc=0 and bypass=0. A write hit sets the line state to modified (code 2). A read hit leaves the state untouched (set_state=0, state code 0).
- R6: When enabled and not restricted, a miss allocates. A read fill gets exclusive (code 1) and a write fill gets modified (code 2).
- R7: In data-only mode, an instruction miss bypasses without allocating, while an instruction hit is still serviced and data misses still allocate.
- R8: In instruction-only mode, data read and write misses bypass without allocating. Data hits, including write hits, are still serviced, and instruction misses allocate.
- R9: With both modes set, no miss allocates, while a write hit still updates the line to modified.
- R10: In write-through mode, every write has bus_wr=1, whether it hits, allocates or bypasses. Every line it writes gets exclusive, never modified.
- R11: An invalidate request while disabled holds `inv_busy` high for NSETS cycles starting the next cycle. During those cycles `inv_idx` runs 0 to NSETS-1, and then `inv_busy` drops.
- R12: An invalidate request while enabled starts no walk and sets `inv_err`. The flag stays set until reset, even after the cache is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_load | input | 1 | Load the four control bits below |
| ctl_enable | input | 1 | Cache enable value to load |
| ctl_data_only | input | 1 | Data-only mode value to load |
| ctl_inst_only | input | 1 | Instruction-only mode value to load |
| ctl_write_thru | input | 1 | Write-through mode value to load |
| inv_req | input | 1 | Global invalidate request pulse |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 fetch, 1 data read, 2 data write |
| req_hit | input | 1 | Tag hit result for this request |
| rsp_valid | output | 1 | Verdict valid |
| rsp_lookup | output | 1 | Cache may be looked up |
| rsp_alloc | output | 1 | Miss allocates a new line |
| rsp_bypass | output | 1 | Request goes around the cache |
| rsp_bus_wr | output | 1 | Store is also written to the system bus |
| rsp_set_state | output | 1 | Line state is written |
| rsp_state | output | 2 | New line state: 0 invalid, 1 exclusive, 2 modified |
| inv_busy | output | 1 | Invalidate walk in progress |
| inv_idx | output | $clog2(NSETS) | Set index being cleared |
| inv_err | output | 1 | Sticky flag: invalidate requested while enabled |

## Verification
The bench hits the cycle in which enable is loaded together with a request. A design that forwarded the enable bit would allocate there instead of bypassing. Write-through store hits and fills are checked for exclusive state, because a design that ignored the mode would mark them modified and leave the bus quiet. Locked mode is checked with misses of every kind and with a store hit, since a design that treated lock as a full bypass would drop the store. The invalidate walk is checked index by index to its length, which catches an off-by-one walk. An invalidate attempted while enabled must leave busy low and the error flag set through a later disable.

// File: rtl/l2pf_pkg.sv
package l2pf_pkg;

    typedef enum logic [1:0] {
        REQ_IFETCH = 2'd0,
        REQ_DREAD  = 2'd1,
        REQ_DWRITE = 2'd2,
        REQ_RSVD   = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        LS_INV  = 2'd0,
        LS_EXC  = 2'd1,
        LS_MOD  = 2'd2,
        LS_RSVD = 2'd3
    } line_st_e;

    typedef struct packed {
        logic en;
        logic data_only;
        logic inst_only;
        logic wthru;
    } ctl_t;

    typedef struct packed {
        logic     lookup;
        logic     alloc;
        logic     bypass;
        logic     bus_wr;
        logic     set_state;
        line_st_e state;
    } verdict_t;

endpackage

// File: rtl/l2pf_ctl_regs.sv
module l2pf_ctl_regs
    import l2pf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_load,
    input  ctl_t ctl_in,
    input  logic inv_req,
    input  logic seq_idle,
    output ctl_t ctl_q,
    output logic inv_go,
    output logic inv_err
);

    // Control register: cleared by reset, used by the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_load) begin
            ctl_q <= ctl_in;
        end
    end

    // An invalidate is only accepted while disabled and idle.
    always_comb begin
        inv_go = inv_req && seq_idle && !ctl_q.en;
    end

    // Sticky error for an invalidate attempted while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_err <= 1'b0;
        end else if (inv_req && ctl_q.en) begin
            inv_err <= 1'b1;
        end
    end

endmodule

// File: rtl/l2pf_inv_seq.sv
module l2pf_inv_seq #(
    parameter  int NSETS = 16,
    localparam int IW    = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    output logic          idle,
    output logic          busy,
    output logic [IW-1:0] idx
);

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WALK = 1'b1
    } seq_st_e;

    localparam logic [IW-1:0] LAST = IW'(NSETS - 1);

    seq_st_e       st_q, st_d;
    logic [IW-1:0] idx_q, idx_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SEQ_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    // Next-state logic: GO enters the walk, DONE leaves it after the last set.
    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        unique case (st_q)
            SEQ_IDLE: begin
                idx_d = '0;
                if (go) begin
                    st_d = SEQ_WALK;
                end
            end
            SEQ_WALK: begin
                if (idx_q == LAST) begin
                    st_d  = SEQ_IDLE;
                    idx_d = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: st_d = SEQ_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        idle = 1'b0;
        busy = 1'b0;
        unique case (st_q)
            SEQ_IDLE: idle = 1'b1;
            SEQ_WALK: busy = 1'b1;
            default:  idle = 1'b1;
        endcase
        idx = idx_q;
    end

endmodule

// File: rtl/l2pf_policy.sv
module l2pf_policy
    import l2pf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  req_kind_e req_kind,
    input  logic      req_hit,
    input  ctl_t      ctl,
    input  logic      walk_busy,
    output logic      rsp_valid,
    output verdict_t  rsp
);

    verdict_t v;
    logic     is_wr;
    logic     is_if;
    logic     no_alloc;

    always_comb begin
        is_wr = 1'b0;
        is_if = 1'b0;
        unique case (req_kind)
            REQ_IFETCH: is_if = 1'b1;
            REQ_DREAD:  ;
            REQ_DWRITE: is_wr = 1'b1;
            REQ_RSVD:   ;
            default:    ;
        endcase
        // Fetch misses are held back by data-only mode, data misses by instruction-only mode.
        no_alloc = is_if ? ctl.data_only : ctl.inst_only;
    end

    always_comb begin
        v = '0;
        if (!ctl.en || walk_busy) begin
            v.bypass = 1'b1;
            v.bus_wr = is_wr;
        end else begin
            v.lookup = 1'b1;
            if (req_hit) begin
                if (is_wr) begin
                    v.set_state = 1'b1;
                    v.state     = ctl.wthru ? LS_EXC : LS_MOD;
                    v.bus_wr    = ctl.wthru;
                end
            end else if (no_alloc) begin
                v.bypass = 1'b1;
                v.bus_wr = is_wr;
            end else begin
                v.alloc     = 1'b1;
                v.set_state = 1'b1;
                v.state     = (is_wr && !ctl.wthru) ? LS_MOD : LS_EXC;
                v.bus_wr    = is_wr && ctl.wthru;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp       <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp       <= req_valid ? v : '0;
        end
    end

endmodule

// File: rtl/l2_alloc_filter.sv
module l2_alloc_filter
    import l2pf_pkg::*;
#(
    parameter  int NSETS = 16,
    localparam int IW    = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_load,
    input  logic          ctl_enable,
    input  logic          ctl_data_only,
    input  logic          ctl_inst_only,
    input  logic          ctl_write_thru,
    input  logic          inv_req,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic          req_hit,
    output logic          rsp_valid,
    output logic          rsp_lookup,
    output logic          rsp_alloc,
    output logic          rsp_bypass,
    output logic          rsp_bus_wr,
    output logic          rsp_set_state,
    output logic [1:0]    rsp_state,
    output logic          inv_busy,
    output logic [IW-1:0] inv_idx,
    output logic          inv_err
);

    ctl_t     ctl_in;
    ctl_t     ctl_q;
    logic     inv_go;
    logic     seq_idle;
    verdict_t rsp;

    always_comb begin
        ctl_in.en        = ctl_enable;
        ctl_in.data_only = ctl_data_only;
        ctl_in.inst_only = ctl_inst_only;
        ctl_in.wthru     = ctl_write_thru;
    end

    l2pf_ctl_regs u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_load (ctl_load),
        .ctl_in   (ctl_in),
        .inv_req  (inv_req),
        .seq_idle (seq_idle),
        .ctl_q    (ctl_q),
        .inv_go   (inv_go),
        .inv_err  (inv_err)
    );

    l2pf_inv_seq #(.NSETS(NSETS)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (inv_go),
        .idle  (seq_idle),
        .busy  (inv_busy),
        .idx   (inv_idx)
    );

    l2pf_policy u_pol (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind_e'(req_kind)),
        .req_hit   (req_hit),
        .ctl       (ctl_q),
        .walk_busy (inv_busy),
        .rsp_valid (rsp_valid),
        .rsp       (rsp)
    );

    always_comb begin
        rsp_lookup    = rsp.lookup;
        rsp_alloc     = rsp.alloc;
        rsp_bypass    = rsp.bypass;
        rsp_bus_wr    = rsp.bus_wr;
        rsp_set_state = rsp.set_state;
        rsp_state     = rsp.state;
    end

endmodule

// File: rtl/l2_alloc_filter_chk.sv
module l2_alloc_filter_chk
    import l2pf_pkg::*;
#(
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          rsp_valid,
    input logic          rsp_lookup,
    input logic          rsp_alloc,
    input logic          rsp_bypass,
    input logic [1:0]    rsp_state,
    input logic          inv_busy,
    input logic [IW-1:0] inv_idx,
    input logic          inv_err,
    input ctl_t          ctl_q
);

    p_disabled_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(ctl_q.en)) |-> (rsp_bypass && !rsp_lookup && !rsp_alloc));

    p_one_response_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_alloc_looked_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_alloc |-> (rsp_lookup && !rsp_bypass));

    p_lock_no_alloc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(ctl_q.data_only && ctl_q.inst_only)) |-> !rsp_alloc);

    p_wt_never_mod_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(ctl_q.wthru)) |-> (rsp_state != 2'd2));

    p_idx_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_busy && $past(inv_busy)) |-> (inv_idx == $past(inv_idx) + 1'b1));

    p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        inv_err |=> inv_err);

endmodule

bind l2_alloc_filter l2_alloc_filter_chk #(.IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_lookup (rsp_lookup),
    .rsp_alloc  (rsp_alloc),
    .rsp_bypass (rsp_bypass),
    .rsp_state  (rsp_state),
    .inv_busy   (inv_busy),
    .inv_idx    (inv_idx),
    .inv_err    (inv_err),
    .ctl_q      (ctl_q)
);

// File: tb/l2_alloc_filter_test.sv
module l2_alloc_filter_test;

    localparam int NSETS = 16;
    localparam int IW    = $clog2(NSETS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_load = 1'b0;
    logic          ctl_enable = 1'b0;
    logic          ctl_data_only = 1'b0;
    logic          ctl_inst_only = 1'b0;
    logic          ctl_write_thru = 1'b0;
    logic          inv_req = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'd0;
    logic          req_hit = 1'b0;
    logic          rsp_valid, rsp_lookup, rsp_alloc, rsp_bypass, rsp_bus_wr, rsp_set_state;
    logic [1:0]    rsp_state;
    logic          inv_busy;
    logic [IW-1:0] inv_idx;
    logic          inv_err;

    always #5 clk = ~clk;

    l2_alloc_filter #(.NSETS(NSETS)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_load(ctl_load), .ctl_enable(ctl_enable),
        .ctl_data_only(ctl_data_only), .ctl_inst_only(ctl_inst_only),
        .ctl_write_thru(ctl_write_thru), .inv_req(inv_req), .req_valid(req_valid),
        .req_kind(req_kind), .req_hit(req_hit), .rsp_valid(rsp_valid),
        .rsp_lookup(rsp_lookup), .rsp_alloc(rsp_alloc), .rsp_bypass(rsp_bypass),
        .rsp_bus_wr(rsp_bus_wr), .rsp_set_state(rsp_set_state), .rsp_state(rsp_state),
        .inv_busy(inv_busy), .inv_idx(inv_idx), .inv_err(inv_err)
    );

    typedef struct {
        logic [6:0] e;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    // Shadow of the control register as the requirements describe it.
    logic s_en = 0, s_do = 0, s_io = 0, s_wt = 0;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected verdict {lookup, alloc, bypass, bus_wr, set_state, state[1:0]}.
    function automatic logic [6:0] model(logic [1:0] k, logic hit);
        logic wr, ifx, restrict_miss;
        wr  = (k == 2'd2);
        ifx = (k == 2'd0);
        restrict_miss = ifx ? s_do : s_io;
        if (!s_en) return {1'b0, 1'b0, 1'b1, wr, 1'b0, 2'd0};
        if (hit) begin
            if (wr) return {1'b1, 1'b0, 1'b0, s_wt, 1'b1, s_wt ? 2'd1 : 2'd2};
            return {1'b1, 6'b0};
        end
        if (restrict_miss) return {1'b1, 1'b0, 1'b1, wr, 1'b0, 2'd0};
        return {1'b1, 1'b1, 1'b0, wr && s_wt, 1'b1, (wr && !s_wt) ? 2'd2 : 2'd1};
    endfunction

    task automatic send(string tag, logic [1:0] k, logic hit);
        exp_t it;
        @(posedge clk); #1;
        req_valid = 1'b1; req_kind = k; req_hit = hit; ctl_load = 1'b0; inv_req = 1'b0;
        it.e = model(k, hit); it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        req_valid = 1'b0; ctl_load = 1'b0; inv_req = 1'b0;
    endtask

    task automatic load(logic en, logic dox, logic iox, logic wt);
        @(posedge clk); #1;
        req_valid = 1'b0; inv_req = 1'b0;
        ctl_load = 1'b1; ctl_enable = en; ctl_data_only = dox;
        ctl_inst_only = iox; ctl_write_thru = wt;
        s_en = en; s_do = dox; s_io = iox; s_wt = wt;
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                chk("R4 unexpected response", 1, 0);
            end else begin
                exp_t it;
                it = q.pop_front();
                chk(it.tag, int'({rsp_lookup, rsp_alloc, rsp_bypass, rsp_bus_wr,
                                  rsp_set_state, rsp_state}), int'(it.e));
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            chk("watchdog", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs", int'({rsp_valid, rsp_lookup, rsp_alloc, rsp_bypass,
                               rsp_bus_wr, rsp_set_state, rsp_state}), 0);
        chk("R1 busy", int'(inv_busy), 0);
        chk("R1 err", int'(inv_err), 0);

        // R2 disabled: everything bypasses
        send("R2 fetch hit disabled", 2'd0, 1'b1);
        send("R2 read miss disabled", 2'd1, 1'b0);
        send("R2 write miss disabled", 2'd2, 1'b0);
        send("R2 reserved kind disabled", 2'd3, 1'b1);

        // R3 load and request in one cycle uses old controls
        @(posedge clk); #1;
        begin
            exp_t it;
            req_valid = 1'b1; req_kind = 2'd1; req_hit = 1'b0;
            it.e = model(2'd1, 1'b0); it.tag = "R3 same-cycle enable";
            q.push_back(it);
            ctl_load = 1'b1; ctl_enable = 1'b1; ctl_data_only = 1'b0;
            ctl_inst_only = 1'b0; ctl_write_thru = 1'b0;
            s_en = 1'b1; s_do = 1'b0; s_io = 1'b0; s_wt = 1'b0;
        end
        send("R3 next request enabled", 2'd1, 1'b0);

        // R5 / R6 normal enabled
        send("R5 write hit modified", 2'd2, 1'b1);
        send("R5 read hit", 2'd1, 1'b1);
        send("R5 fetch hit", 2'd0, 1'b1);
        send("R6 write miss alloc", 2'd2, 1'b0);
        send("R6 fetch miss alloc", 2'd0, 1'b0);

        // R7 data-only
        load(1, 1, 0, 0);
        send("R7 fetch miss bypass", 2'd0, 1'b0);
        send("R7 fetch hit served", 2'd0, 1'b1);
        send("R7 read miss alloc", 2'd1, 1'b0);

        // R8 instruction-only
        load(1, 0, 1, 0);
        send("R8 read miss bypass", 2'd1, 1'b0);
        send("R8 write miss bypass", 2'd2, 1'b0);
        send("R8 write hit served", 2'd2, 1'b1);
        send("R8 fetch miss alloc", 2'd0, 1'b0);

        // R9 locked
        load(1, 1, 1, 0);
        send("R9 fetch miss locked", 2'd0, 1'b0);
        send("R9 read miss locked", 2'd1, 1'b0);
        send("R9 write miss locked", 2'd2, 1'b0);
        send("R9 write hit locked", 2'd2, 1'b1);

        // R10 write-through
        load(1, 0, 0, 1);
        send("R10 write hit wt", 2'd2, 1'b1);
        send("R10 write miss wt", 2'd2, 1'b0);
        send("R10 read miss wt", 2'd1, 1'b0);
        load(1, 1, 1, 1);
        send("R10 write miss wt locked", 2'd2, 1'b0);
        idle();
        idle();

        // R12 invalidate while enabled
        @(posedge clk); #1;
        inv_req = 1'b1;
        @(posedge clk); #1;
        inv_req = 1'b0;
        @(negedge clk);
        chk("R12 no walk", int'(inv_busy), 0);
        chk("R12 err set", int'(inv_err), 1);

        // R11 invalidate while disabled
        load(0, 0, 0, 0);
        idle();
        @(posedge clk); #1;
        inv_req = 1'b1;
        @(posedge clk); #1;
        inv_req = 1'b0;
        for (int k = 0; k < NSETS; k++) begin
            if (k > 0) @(negedge clk);
            else @(negedge clk);
            chk($sformatf("R11 busy step %0d", k), int'(inv_busy), 1);
            chk($sformatf("R11 idx step %0d", k), int'(inv_idx), k);
        end
        @(negedge clk);
        chk("R11 busy cleared", int'(inv_busy), 0);
        chk("R12 err still set", int'(inv_err), 1);

        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R4 all responses seen", q.size(), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule